// File: doc/BRIEF.md
# Idle clock gating controller

This block puts a small processor core into a low-power idle state and brings it back out. It runs on the oscillator clock and drives two clock enables: one for the CPU and one shared by all peripherals (interrupt logic, timers, the counter array, serial interfaces, the converter and the watchdog). Software writes a 1 into bit 0 of the control register to go idle. From the next cycle the CPU enable is held low. The peripheral enable keeps pulsing, slowed by a power-of-two ratio that software chose beforehand in the clock-select register.

Idle ends in one of two ways. The first is any interrupt request whose enable bit is set. Requests are sampled on every oscillator cycle. The hardware then clears the idle bit, restores full-speed clocking and raises a one-cycle wake event. The second is the external reset, which returns the whole block to its reset state.

The control state machine has three states:
- `ST_RUN`: normal operation.
- `ST_IDLE`: CPU gated, peripheral clock divided.
- `ST_WAKE`: the first cycle after an interrupt wake.

It has these transitions:
- RUN→IDLE and WAKE→IDLE on an idle write.
- IDLE→WAKE on an enabled request.
- WAKE→RUN otherwise.
- Any state→RUN on reset.

Top module: `idle_clk_ctrl`

## Requirements
- R1: A write to register address 0 with bit 0 set, made outside idle, gives `idle_o`=1 and `cpu_clk_en`=0 from the next cycle. A write with bit 0 clear leaves the block running.
- R2: For every idle cycle, `cpu_clk_en` stays 0 while `periph_clk_en` keeps being produced by the divider.
- R3: An idle cycle in which some `irq_req[i]` and `irq_en[i]` are both 1 is followed by a cycle with `idle_o`=0, `cpu_clk_en`=1, `wake_evt`=1 and control bit 0 reading 0. `wake_evt` lasts exactly one cycle. Requests whose enable bit is 0 never end idle.
- R4: While `rst_n` is low, the block is in run mode with `cpu_clk_en`=1, `periph_clk_en`=1 and `wake_evt`=0, and both registers read 0. This also holds when reset arrives during idle.
- R5: Register address 1 holds the 3-bit select N in bits 2:0 and reads 0 in bits 7:3. Register address 0 reads the idle bit in bit 0 and 0 in bits 7:1. `reg_rdata` shows the register selected by `reg_addr`, and the select value survives across idle periods.
- R6: In idle with select N, `periph_clk_en` is 1 for one cycle and then 0 for 2^N−1 cycles (divide by 2^N, N = 0..7). With N=0 it is 1 every cycle.
- R7: Outside idle, including the wake cycle, `periph_clk_en` is 1 on every cycle whatever the select value.
- R8: The divider restarts on idle entry. Counting the first idle cycle as 0, the enable is 1 exactly on idle cycles k with k mod 2^N = 2^N−1.
- R9: Wake latency is one cycle for every N, including a request in idle cycle 0 with N=7.
- R10: Register writes while idle are ignored. The select value read after wake equals the value held before entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 idle clock select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_req | input | 8 | Interrupt request lines |
| irq_en | input | 8 | Per-line interrupt enables |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| idle_o | output | 1 | High while in idle |
| wake_evt | output | 1 | One-cycle pulse on interrupt wake |

## Verification
Several properties are checked by assertions on every cycle:
- an idle write leads to the idle state, and an enabled request leads to the wake state with the idle bit cleared;
- idle only ends through a wake pulse;
- the peripheral enable is high outside idle;
- a divided pulse lasts a single cycle;
- the divider is at zero on entry;
- the select register holds still under writes in idle.

Other behaviour only the bench scenarios can show: the exact divide ratio and the phase of the first pulse for each select value, the wake latency at the largest ratio, the readback values, and recovery through reset in the middle of idle.

// File: rtl/idle_clk_pkg.sv
package idle_clk_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_IDLE = 2'd1,
        ST_WAKE = 2'd2
    } pm_state_t;

    localparam int unsigned CTRL_ADDR = 0;
    localparam int unsigned CKS_ADDR  = 1;

endpackage

// File: rtl/idle_regs.sv
module idle_regs #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 1,
    parameter int unsigned SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hw_clear,
    output logic              enter_req,
    output logic              idle_bit,
    output logic [SEL_W-1:0]  cks_sel,
    output logic [DATA_W-1:0] rdata
);
    import idle_clk_pkg::*;

    logic ctrl_hit;
    logic cks_hit;
    logic unused_wdata;

    assign ctrl_hit     = we && wr_ok && (addr == ADDR_W'(CTRL_ADDR));
    assign cks_hit      = we && wr_ok && (addr == ADDR_W'(CKS_ADDR));
    assign enter_req    = ctrl_hit && wdata[0];
    assign unused_wdata = ^wdata[DATA_W-1:SEL_W];

    // idle bit: set by software, cleared by hardware wake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_bit <= 1'b0;
        end else if (hw_clear) begin
            idle_bit <= 1'b0;
        end else if (ctrl_hit) begin
            idle_bit <= wdata[0];
        end
    end

    // idle clock select field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cks_sel <= '0;
        end else if (cks_hit) begin
            cks_sel <= wdata[SEL_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_ADDR)) begin
            rdata[0] = idle_bit;
        end else if (addr == ADDR_W'(CKS_ADDR)) begin
            rdata[SEL_W-1:0] = cks_sel;
        end
    end

    AST_IDLE_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wr_ok) |=> $stable(cks_sel)); // R10

endmodule

// File: rtl/idle_fsm.sv
module idle_fsm #(
    parameter int unsigned NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enter_req,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               idle_bit,
    output logic               wr_ok,
    output logic               hw_clear,
    output logic               div_clear,
    output logic               in_idle,
    output logic               cpu_en,
    output logic               wake_pulse
);
    import idle_clk_pkg::*;

    pm_state_t state;
    pm_state_t state_nx;
    logic      wake_req;

    // sampled every oscillator cycle, independent of the divide ratio
    assign wake_req = |(irq_req & irq_en);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (enter_req) state_nx = ST_IDLE;
            ST_IDLE: if (wake_req)  state_nx = ST_WAKE;
            ST_WAKE: state_nx = enter_req ? ST_IDLE : ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        wr_ok      = 1'b1;
        hw_clear   = 1'b0;
        div_clear  = 1'b0;
        in_idle    = 1'b0;
        cpu_en     = 1'b1;
        wake_pulse = 1'b0;
        unique case (state)
            ST_RUN: begin
                div_clear = enter_req;
            end
            ST_IDLE: begin
                wr_ok    = 1'b0;
                in_idle  = 1'b1;
                cpu_en   = 1'b0;
                hw_clear = wake_req;
            end
            ST_WAKE: begin
                wake_pulse = 1'b1;
                div_clear  = enter_req;
            end
            default: begin
                wr_ok = 1'b1;
            end
        endcase
    end

    AST_ENTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        enter_req |=> (state == ST_IDLE && idle_bit)); // R1

    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wake_req) |=> (state == ST_WAKE && !idle_bit)); // R3

    AST_WAKE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !wake_req) |=> (state == ST_IDLE)); // R9

endmodule

// File: rtl/idle_div.sv
module idle_div #(
    parameter int unsigned DIV_W = 7,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             in_idle,
    input  logic [SEL_W-1:0] sel,
    output logic             periph_en
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] mask;
    logic             tick;

    // mask of the low N bits, N = sel
    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign mask[i] = (int'(sel) > i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick      = &(cnt | ~mask);
    assign periph_en = !in_idle || tick;

    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_idle) |-> (cnt == '0)); // R8

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && sel != '0 && periph_en) |=> (!periph_en || !in_idle)); // R6

endmodule

// File: rtl/idle_clk_ctrl.sv
module idle_clk_ctrl #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ADDR_W  = 1,
    parameter int unsigned NUM_IRQ = 8,
    parameter int unsigned DIV_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic               cpu_clk_en,
    output logic               periph_clk_en,
    output logic               idle_o,
    output logic               wake_evt
);
    localparam int unsigned SEL_W = $clog2(DIV_W + 1);

    logic             wr_ok;
    logic             hw_clear;
    logic             div_clear;
    logic             enter_req;
    logic             idle_bit;
    logic [SEL_W-1:0] cks_sel;

    idle_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (wr_ok),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .hw_clear  (hw_clear),
        .enter_req (enter_req),
        .idle_bit  (idle_bit),
        .cks_sel   (cks_sel),
        .rdata     (reg_rdata)
    );

    idle_fsm #(
        .NUM_IRQ (NUM_IRQ)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_req  (enter_req),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .idle_bit   (idle_bit),
        .wr_ok      (wr_ok),
        .hw_clear   (hw_clear),
        .div_clear  (div_clear),
        .in_idle    (idle_o),
        .cpu_en     (cpu_clk_en),
        .wake_pulse (wake_evt)
    );

    idle_div #(
        .DIV_W (DIV_W),
        .SEL_W (SEL_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (div_clear),
        .in_idle   (idle_o),
        .sel       (cks_sel),
        .periph_en (periph_clk_en)
    );

    AST_RUN_FULL_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_o |-> periph_clk_en); // R7

    AST_EXIT_VIA_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle_o) |-> (wake_evt && cpu_clk_en)); // R3

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !wake_evt); // R3

endmodule

// File: tb/tb_idle_clk_ctrl.sv
module tb_idle_clk_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_we;
    logic [0:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [7:0] irq_req;
    logic [7:0] irq_en;
    logic       cpu_clk_en;
    logic       periph_clk_en;
    logic       idle_o;
    logic       wake_evt;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    idle_clk_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq_req       (irq_req),
        .irq_en        (irq_en),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .idle_o        (idle_o),
        .wake_evt      (wake_evt)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_pen(int k, int n);
        int m = (1 << n) - 1;
        return ((k & m) == m) ? 1 : 0;
    endfunction

    // at a negedge: write one register, return at the next negedge
    task automatic wr(int a, int d);
        reg_we    = 1'b1;
        reg_addr  = 1'(a);
        reg_wdata = 8'(d);
        @(negedge clk);
        reg_we    = 1'b0;
        reg_addr  = 1'b0;
    endtask

    task automatic rd_check(string tag, int a, int exp);
        reg_addr = 1'(a);
        #1;
        check(tag, int'(reg_rdata), exp);
        reg_addr = 1'b0;
    endtask

    // select must already be n; enter idle, stay len cycles, wake on an enabled line
    task automatic idle_run(int n, int len, bit try_write, bit noise);
        int en;
        en = 0;
        while (en == 0) en = int'($urandom_range(255, 1));
        irq_en = 8'(en);
        wr(0, 8'h01); // R1 entry
        for (int k = 0; k < len; k++) begin
            check("R1 idle_o in idle", int'(idle_o), 1);
            check("R2 cpu_clk_en off in idle", int'(cpu_clk_en), 0);
            check("R6 R8 divided periph_clk_en", int'(periph_clk_en), exp_pen(k, n));
            reg_we = 1'b0;
            if (k == 0) begin
                #1;
                check("R5 ctrl reads idle", int'(reg_rdata), 1);
                if (try_write) begin
                    reg_we    = 1'b1;
                    reg_addr  = 1'b1;
                    reg_wdata = 8'h05; // R10 must be ignored
                end
            end
            if (k == len - 1) begin
                irq_req = 8'(en & -en);
            end else if (noise) begin
                irq_req = 8'($urandom_range(255, 0) & ~en); // R3 disabled lines
            end else begin
                irq_req = 8'h00;
            end
            @(negedge clk);
            reg_we   = 1'b0;
            reg_addr = 1'b0;
        end
        irq_req = 8'h00;
        check("R3 R9 wake_evt", int'(wake_evt), 1);
        check("R3 idle_o cleared", int'(idle_o), 0);
        check("R3 cpu_clk_en back", int'(cpu_clk_en), 1);
        check("R7 periph full speed on wake", int'(periph_clk_en), 1);
        rd_check("R3 idle bit cleared", 0, 0);
        @(negedge clk);
        check("R3 wake_evt one cycle", int'(wake_evt), 0);
        check("R7 periph full speed in run", int'(periph_clk_en), 1);
        rd_check("R5 R10 select kept", 1, n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
        irq_req = 8'h00; irq_en = 8'h00;
        repeat (3) @(negedge clk);
        check("R4 reset cpu_clk_en", int'(cpu_clk_en), 1);
        check("R4 reset periph_clk_en", int'(periph_clk_en), 1);
        check("R4 reset idle_o", int'(idle_o), 0);
        check("R4 reset wake_evt", int'(wake_evt), 0);
        rd_check("R4 reset ctrl", 0, 0);
        rd_check("R4 reset select", 1, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: bit 0 clear does not enter idle
        wr(0, 8'hFE);
        check("R1 no entry on bit0=0", int'(idle_o), 0);
        check("R1 cpu runs", int'(cpu_clk_en), 1);
        rd_check("R5 ctrl upper bits zero", 0, 0);

        // R5: select field, upper bits read zero; R7 run full speed with N set
        wr(1, 8'hFB);
        rd_check("R5 select readback", 1, 3);
        check("R7 run periph with N=3", int'(periph_clk_en), 1);

        // R6 R8 R10: N=3 with ignored write during idle
        idle_run(3, 20, 1'b1, 1'b0);

        // R9: N=7, request in idle cycle 0
        wr(1, 7);
        idle_run(7, 1, 1'b0, 1'b0);

        // R6: N=0, enable every cycle
        wr(1, 0);
        idle_run(0, 6, 1'b0, 1'b0);

        // R3: disabled requests only, long window at N=7
        wr(1, 7);
        idle_run(7, 300, 1'b0, 1'b1);

        // R4: reset in the middle of idle
        wr(1, 2);
        wr(0, 1);
        repeat (3) @(negedge clk);
        check("R1 idle before reset", int'(idle_o), 1);
        rst_n = 1'b0;
        #1;
        check("R4 reset ends idle", int'(idle_o), 0);
        check("R4 reset cpu on", int'(cpu_clk_en), 1);
        check("R4 reset periph on", int'(periph_clk_en), 1);
        rd_check("R4 reset clears ctrl", 0, 0);
        rd_check("R4 reset clears select", 1, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // random trials
        for (int t = 0; t < 40; t++) begin
            int n;
            int len;
            n   = int'($urandom_range(7, 0));
            len = int'($urandom_range(300, 1));
            wr(1, n | (int'($urandom_range(31, 0)) << 3));
            rd_check("R5 random select readback", 1, n);
            idle_run(n, len, 1'(t % 2), 1'b1);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule